// File: doc/BRIEF.md
# Filtered Gate-Drive Fault Shutdown Unit

This unit stands between a PWM generator and the gate-driver pins of two three-phase motor inverters and one power-factor-correction (PFC) stage. It watches three fault pins: one for each motor and one for the PFC stage. Each pin is synchronised to the system clock and passes through a digital glitch filter before it takes effect. A filtered fault sets a sticky latch. While that latch is set, the matching group of gate outputs is held at its inactive level: six lines for each motor, one line for the PFC stage.

The PWM demand arrives on input ports as logical "switch on" levels. The unit maps each line to a physical pin level through a per-line polarity bit. Software uses a small three-word register port for three things:

- choosing the sense of each fault pin;
- choosing the polarity of each gate line;
- reading and clearing the latched faults.

The PFC fault pin can be handed over to general-purpose use. In that mode the motor-one fault also shuts the PFC output down.

Top module: `pwm_fault_guard`

## Requirements
- R1: A latched motor-one fault holds all six motor-one gate outputs at their inactive level. The motor-two outputs are not affected.
- R2: A latched motor-two fault holds all six motor-two gate outputs at their inactive level. The motor-one outputs are not affected.
- R3: Register 0 bits 0, 1 and 2 set the sense of the motor-one, motor-two and PFC fault pins. A value of 0 means the fault is asserted when the pin is high. A value of 1 means the fault is asserted when the pin is low.
- R4: A fault pin that is asserted for fewer than FILT_CYC consecutive clock samples is ignored. A fault pin that is held for FILT_CYC samples is recognised.
- R5: With register 0 bit 3 at 0, a latched PFC fault forces only the PFC gate output inactive.
- R6: With register 0 bit 3 at 1, the PFC fault pin has no effect on any gate output, and a latched motor-one fault also forces the PFC output inactive.
- R7: Register 1 holds one polarity bit per gate line. Bits [5:0] are motor one, bits [11:6] are motor two and bit 12 is PFC. A bit of 0 means the line is high when on. A bit of 1 means the line is low when on. Each pin therefore equals its demand XOR its polarity bit, and its inactive level equals its polarity bit.
- R8: A fault pin asserted from one clock edge onward drives its outputs inactive on the (FILT_CYC+4)th rising edge, counting that edge as the first. At the default of 64 this is 68 edges, within 100.
- R9: Reading register 2 returns the fault latches in bits [2:0] (motor one, motor two, PFC) and the filtered fault levels in bits [5:3]. A latch stays set after its pin returns to inactive. Writing 1 to a bit of register 2 clears that latch only while its filtered level is inactive.
- R10: While reset is held, every gate output is low and registers 0, 1 and 2 read zero, so every line is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1_kill_pin | input | 1 | Motor-one fault pin, raw |
| m2_kill_pin | input | 1 | Motor-two fault pin, raw |
| pfc_kill_pin | input | 1 | PFC fault pin, raw |
| m1_pwm | input | MOT_LINES | Motor-one gate demand, 1 = switch on |
| m2_pwm | input | MOT_LINES | Motor-two gate demand, 1 = switch on |
| pfc_pwm | input | 1 | PFC gate demand, 1 = switch on |
| m1_gate | output | MOT_LINES | Motor-one gate-driver pins |
| m2_gate | output | MOT_LINES | Motor-two gate-driver pins |
| pfc_gate | output | 1 | PFC gate-driver pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |

## Verification
The bench targets the following corner cases:

- A fault pulse one sample shorter than the filter window, which a filter with an off-by-one would let through and so shut the motor down.
- The exact edge on which the outputs go off, which exposes a missing or extra pipeline stage.
- A clear written while the fault is still asserted, which a careless latch would honour and so re-enable the drive under fault.
- A switch to the low-true sense while the pin idles low, which must raise a fault.
- The general-I/O mode, where a design that still obeyed the PFC pin, or ignored the motor-one fault for the PFC line, would leave the PFC stage in the wrong state.

A behavioural model tracks every output and the read port on every clock, so a latch that clears by itself or a polarity applied to the wrong line shows up on the cycle it goes wrong.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int FILT_CYC  = 64,
  parameter int MOT_LINES = 6,
  parameter int DW        = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m1_kill_pin,
  input  logic                 m2_kill_pin,
  input  logic                 pfc_kill_pin,
  input  logic [MOT_LINES-1:0] m1_pwm,
  input  logic [MOT_LINES-1:0] m2_pwm,
  input  logic                 pfc_pwm,
  output logic [MOT_LINES-1:0] m1_gate,
  output logic [MOT_LINES-1:0] m2_gate,
  output logic                 pfc_gate,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata
);
  localparam int POL_W = 2*MOT_LINES + 1;
  localparam int CW    = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

  logic [2:0]       s1, s2, filt, lat;
  logic [3:0]       cfg;
  logic [POL_W-1:0] pol;

  wire [2:0] act = s2 ^ cfg[2:0];
  wire [2:0] clr = (reg_we && reg_addr == 2'd2) ? reg_wdata[2:0] : 3'b000;
  wire       pfc_kill = cfg[3] ? lat[0] : lat[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {pfc_kill_pin, m2_kill_pin, m1_kill_pin};
      s2 <= s1;
    end

  for (genvar g = 0; g < 3; g++) begin : g_filt
    logic [CW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        lvl <= 1'b0;
      end else if (act[g] == lvl) begin
        cnt <= '0;
      end else if (cnt == LIM) begin
        lvl <= act[g];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign filt[g] = lvl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat <= '0;
    else        lat <= filt | (lat & ~clr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= '0;
      pol <= '0;
    end else if (reg_we) begin
      if (reg_addr == 2'd0) cfg <= reg_wdata[3:0];
      if (reg_addr == 2'd1) pol <= reg_wdata[POL_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1_gate  <= '0;
      m2_gate  <= '0;
      pfc_gate <= 1'b0;
    end else begin
      m1_gate  <= (m1_pwm & ~{MOT_LINES{lat[0]}}) ^ pol[MOT_LINES-1:0];
      m2_gate  <= (m2_pwm & ~{MOT_LINES{lat[1]}}) ^ pol[2*MOT_LINES-1:MOT_LINES];
      pfc_gate <= (pfc_pwm & ~pfc_kill) ^ pol[2*MOT_LINES];
    end

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = DW'(cfg);
      2'd1:    reg_rdata = DW'(pol);
      2'd2:    reg_rdata = DW'({filt, lat});
      default: reg_rdata = '0;
    endcase
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int MOT_LINES = 6,
  parameter int DW        = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             filt,
  input logic [2:0]             lat,
  input logic [3:0]             cfg,
  input logic [2*MOT_LINES:0]   pol,
  input logic [MOT_LINES-1:0]   m1_gate,
  input logic [MOT_LINES-1:0]   m2_gate,
  input logic                   pfc_gate,
  input logic                   reg_we,
  input logic [1:0]             reg_addr,
  input logic [DW-1:0]          reg_wdata
);
  wire clr0 = reg_we && reg_addr == 2'd2 && reg_wdata[0];

  a_r1_m1_off: assert property (@(posedge clk) disable iff (!rst_n)
    lat[0] |=> m1_gate == $past(pol[MOT_LINES-1:0]));

  a_r2_m2_off: assert property (@(posedge clk) disable iff (!rst_n)
    lat[1] |=> m2_gate == $past(pol[2*MOT_LINES-1:MOT_LINES]));

  a_r5_pfc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[3] && lat[2]) |=> pfc_gate == $past(pol[2*MOT_LINES]));

  a_r6_pfc_by_m1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3] && lat[0]) |=> pfc_gate == $past(pol[2*MOT_LINES]));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lat[0] && !clr0) |=> lat[0]);

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    filt[1] |=> lat[1]);
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.MOT_LINES(MOT_LINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt(filt), .lat(lat), .cfg(cfg), .pol(pol),
  .m1_gate(m1_gate), .m2_gate(m2_gate), .pfc_gate(pfc_gate),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/pwm_fault_guard_tb.sv
module pwm_fault_guard_tb;
  localparam int CLK_PER = 10;
  localparam int F = 64;

  logic clk = 0, rst_n = 0;
  logic m1k = 0, m2k = 0, pk = 0;
  logic [5:0] m1_pwm = 0, m2_pwm = 0;
  logic pfc_pwm = 0;
  logic [5:0] m1_gate, m2_gate;
  logic pfc_gate;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  pwm_fault_guard #(.FILT_CYC(F), .MOT_LINES(6), .DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .m1_kill_pin(m1k), .m2_kill_pin(m2k),
    .pfc_kill_pin(pk), .m1_pwm(m1_pwm), .m2_pwm(m2_pwm), .pfc_pwm(pfc_pwm),
    .m1_gate(m1_gate), .m2_gate(m2_gate), .pfc_gate(pfc_gate),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int   run[3];
  bit   d1[3], d2[3], mf[3], ml[3];
  bit [3:0]  mcfg;
  bit [12:0] mpol;
  bit [5:0]  e_m1, e_m2;
  bit        e_pfc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        run[i] = 0; d1[i] = 0; d2[i] = 0; mf[i] = 0; ml[i] = 0;
      end
      mcfg = 0; mpol = 0; e_m1 = 0; e_m2 = 0; e_pfc = 0;
    end else begin
      bit pk_eff;
      pk_eff = mcfg[3] ? ml[0] : ml[2];
      e_m1  = (ml[0] ? 6'd0 : m1_pwm) ^ mpol[5:0];
      e_m2  = (ml[1] ? 6'd0 : m2_pwm) ^ mpol[11:6];
      e_pfc = (pk_eff ? 1'b0 : pfc_pwm) ^ mpol[12];
      for (int i = 0; i < 3; i++) begin
        bit a;
        if (mf[i]) ml[i] = 1;
        else if (reg_we && reg_addr == 2 && reg_wdata[i]) ml[i] = 0;
        a = d2[i] ^ mcfg[i];
        if (a == mf[i]) run[i] = 0;
        else begin
          run[i]++;
          if (run[i] == F) begin mf[i] = a; run[i] = 0; end
        end
        d2[i] = d1[i];
      end
      d1[0] = m1k; d1[1] = m2k; d1[2] = pk;
      if (reg_we && reg_addr == 0) mcfg = reg_wdata[3:0];
      if (reg_we && reg_addr == 1) mpol = reg_wdata[12:0];
    end
  end

  always @(posedge clk) begin
    #(CLK_PER/4);
    if (rst_n && !done) begin
      logic [15:0] er;
      case (reg_addr)
        0: er = {12'd0, mcfg};
        1: er = {3'd0, mpol};
        2: er = {10'd0, mf[2], mf[1], mf[0], ml[2], ml[1], ml[0]};
        default: er = 0;
      endcase
      chk(m1_gate == e_m1, "R1 model m1_gate", m1_gate, e_m1);
      chk(m2_gate == e_m2, "R2 model m2_gate", m2_gate, e_m2);
      chk(pfc_gate == e_pfc, "R5 model pfc_gate", pfc_gate, e_pfc);
      chk(reg_rdata == er, "R9 model reg_rdata", reg_rdata, er);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = 2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata; reg_addr = 2;
  endtask

  logic [15:0] r;
  logic [12:0] pl;

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    reg_addr = 2;
    wait_n(4);
    // R10 reset state
    chk(m1_gate == 0 && m2_gate == 0 && pfc_gate == 0, "R10 gates in reset",
        {m1_gate, m2_gate, pfc_gate}, 0);
    rd(0, r); chk(r == 0, "R10 reg0 reset", r, 0);
    rd(1, r); chk(r == 0, "R10 reg1 reset", r, 0);
    rd(2, r); chk(r == 0, "R10 reg2 reset", r, 0);
    @(negedge clk); rst_n = 1;

    m1_pwm = 6'b101101; m2_pwm = 6'b010011; pfc_pwm = 1;
    wait_n(3);
    chk(m1_gate == 6'b101101, "R7 m1 high-true", m1_gate, 6'b101101);
    chk(m2_gate == 6'b010011, "R7 m2 high-true", m2_gate, 6'b010011);
    pl = 13'h1555;
    wr(1, {3'd0, pl});
    wait_n(2);
    chk(m1_gate == (6'b101101 ^ pl[5:0]), "R7 m1 polarity", m1_gate, 6'b101101 ^ pl[5:0]);
    chk(m2_gate == (6'b010011 ^ pl[11:6]), "R7 m2 polarity", m2_gate, 6'b010011 ^ pl[11:6]);
    chk(pfc_gate == (1'b1 ^ pl[12]), "R7 pfc polarity", pfc_gate, 1'b1 ^ pl[12]);

    // R4 short pulse ignored
    m1k = 1; wait_n(F-1); m1k = 0;
    wait_n(F + 10);
    chk(m1_gate == (m1_pwm ^ pl[5:0]), "R4 short pulse ignored", m1_gate, m1_pwm ^ pl[5:0]);
    rd(2, r); chk(r == 0, "R4 no latch after short pulse", r, 0);

    // R8 latency and R1 isolation
    begin
      int k;
      k = 0;
      m1k = 1;
      for (int i = 1; i <= 150; i++) begin
        @(posedge clk); #1;
        if (m1_gate == pl[5:0] && k == 0) k = i;
      end
      chk(k == F + 4, "R8 shutdown edge", k, F + 4);
    end
    @(negedge clk);
    chk(m1_gate == pl[5:0], "R1 m1 all inactive", m1_gate, pl[5:0]);
    chk(m2_gate == (m2_pwm ^ pl[11:6]), "R1 m2 untouched", m2_gate, m2_pwm ^ pl[11:6]);

    // R9 clear while active is ignored, latch sticky
    wr(2, 16'h0001); wait_n(2);
    rd(2, r); chk(r[0] == 1, "R9 clear ignored while active", r[0], 1);
    m1k = 0; wait_n(F + 6);
    rd(2, r); chk(r[0] == 1 && r[3] == 0, "R9 latch sticky", r[5:0], 6'b000001);
    chk(m1_gate == pl[5:0], "R9 outputs stay off", m1_gate, pl[5:0]);
    wr(2, 16'h0001); wait_n(2);
    rd(2, r); chk(r == 0, "R9 cleared", r, 0);
    chk(m1_gate == (m1_pwm ^ pl[5:0]), "R9 outputs resume", m1_gate, m1_pwm ^ pl[5:0]);

    // R2
    m2_pwm = 6'b111001;
    m2k = 1; wait_n(F + 8);
    chk(m2_gate == pl[11:6], "R2 m2 all inactive", m2_gate, pl[11:6]);
    chk(m1_gate == (m1_pwm ^ pl[5:0]), "R2 m1 untouched", m1_gate, m1_pwm ^ pl[5:0]);
    m2k = 0; wait_n(F + 6); wr(2, 16'h0002); wait_n(2);

    // R3 low-true sense: pin idling low becomes a fault
    wr(0, 16'h0001); wait_n(F + 8);
    chk(m1_gate == pl[5:0], "R3 low-true pin low faults", m1_gate, pl[5:0]);
    m1k = 1; wait_n(F + 6); wr(2, 16'h0001); wait_n(2);
    chk(m1_gate == (m1_pwm ^ pl[5:0]), "R3 low-true pin high clear", m1_gate, m1_pwm ^ pl[5:0]);
    m1k = 0; wr(0, 16'h0000); wait_n(F + 6);
    rd(2, r); chk(r == 0, "R3 brief sense glitch filtered", r, 0);

    // R5
    pk = 1; wait_n(F + 8);
    chk(pfc_gate == pl[12], "R5 pfc inactive", pfc_gate, pl[12]);
    chk(m1_gate == (m1_pwm ^ pl[5:0]) && m2_gate == (m2_pwm ^ pl[11:6]),
        "R5 motors untouched", {m1_gate, m2_gate}, {m1_pwm ^ pl[5:0], m2_pwm ^ pl[11:6]});
    pk = 0; wait_n(F + 6); wr(2, 16'h0004); wait_n(2);

    // R6 general-I/O mode
    wr(0, 16'h0008);
    pk = 1; wait_n(F + 8);
    chk(pfc_gate == (pfc_pwm ^ pl[12]), "R6 pfc pin ignored", pfc_gate, pfc_pwm ^ pl[12]);
    m1k = 1; wait_n(F + 8);
    chk(pfc_gate == pl[12], "R6 m1 fault kills pfc", pfc_gate, pl[12]);
    m1k = 0; pk = 0; wait_n(F + 6); wr(2, 16'h0007); wait_n(2);
    chk(pfc_gate == (pfc_pwm ^ pl[12]), "R6 pfc resumes", pfc_gate, pfc_pwm ^ pl[12]);

    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      m1_pwm = 6'(i * 7); m2_pwm = 6'(i * 13 + 5); pfc_pwm = i[0];
    end
    wait_n(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule